// File: doc/BRIEF.md
# Host Command Register Port

This block is the host-facing command window of a cell-processing engine. A host CPU places an optional operand in the extended register and then writes a command word into the command register. That write is the only thing that can start work. The port takes one command at a time. It raises a busy bit, gives the decoded command and a private copy of its operand to the execution logic with a one-cycle start pulse, and then waits for a done strobe.

When the command finishes, busy drops and the port writes the result back. Some commands replace the command register contents with a completion indication that carries a status byte. Others leave the written word in place. Any command may return a data word, which goes into the extended register. A host that writes a command while busy loses that command, and a sticky error flag records the loss. A code outside the eleven defined commands finishes at once with an error mark and never reaches the execution logic.

Top module: `hcmd_port`

## Requirements
- R1: After reset, `rd_cmd`, `rd_ext`, `exe_start`, `exe_arg` and `drop_err` are all zero.
- R2: A command-register write (`hst_wr_sel`=0) of a defined code (0..10, in bits [3:0]) while idle sets busy (`rd_cmd[31]`) on that clock edge. It also pulses `exe_start` for exactly one cycle, with `exe_kind` equal to the code.
- R3: Busy stays 1 until `exe_done` is sampled high, and it reads 0 from the following cycle on.
- R4: An extended-register write (`hst_wr_sel`=1) stores `hst_wr_data` in `rd_ext` and never sets busy or pulses `exe_start`.
- R5: At acceptance, `exe_arg` takes the extended register value for code 8, for code 7, and for code 5 with bit 4 (IP-over-ATM select) set. For every other command it takes zero. Later extended writes leave `exe_arg` unchanged while busy.
- R6: On completion of codes 1, 2, 3, 4, 5 or 7, `rd_cmd` becomes an indication word: bit 30 = 1, bits [23:16] = `exe_status`, bits [3:0] = code, and all other bits 0.
- R7: On completion of codes 0, 6, 8, 9 or 10, `rd_cmd` holds the word that was written, with bits 31..29 cleared.
- R8: If `exe_rdata_vld` is high together with `exe_done`, `rd_ext` takes `exe_rdata`. Otherwise `rd_ext` keeps its value.
- R9: A command-register write while busy is dropped: `rd_cmd` is unchanged, no `exe_start` is issued, and `drop_err` becomes 1 and stays 1.
- R10: A command write of an undefined code (11..15) while idle leaves busy at 0 and issues no `exe_start`. `rd_cmd` becomes bit 29 = 1 with the code in bits [3:0] and all other bits 0.
- R11: `hst_err_clr` clears `drop_err`. If a drop happens in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_wr_en | input | 1 | Host write strobe |
| hst_wr_sel | input | 1 | Write target: 0 command register, 1 extended register |
| hst_wr_data | input | 32 | Host write data |
| hst_err_clr | input | 1 | Clears the dropped-command flag |
| rd_cmd | output | 32 | Command register read value (busy in bit 31) |
| rd_ext | output | 32 | Extended register read value |
| drop_err | output | 1 | Sticky flag: a command was written while busy |
| exe_start | output | 1 | One-cycle start pulse to the execution logic |
| exe_kind | output | 4 | Decoded command code for the execution logic |
| exe_arg | output | 32 | Operand captured when the command was accepted |
| exe_done | input | 1 | Execution finished strobe |
| exe_status | input | 8 | Completion status for the indication word |
| exe_rdata | input | 32 | Result data returned by the execution logic |
| exe_rdata_vld | input | 1 | `exe_rdata` is valid together with `exe_done` |

## Verification
On every cycle, the assertions check the busy handshake: acceptance leads to busy and a single start pulse, busy holds until done and drops after it, and an undefined code or an extended-only write never starts anything. They also check that the operand stays frozen while busy and that a write while busy raises the drop flag without a start. The exact words left in the command and extended registers can only be shown by the bench's scenarios. These are the indication layout, the status byte, the cleared top bits, the operand selection per code and IP-over-ATM select, and the result write-back. The same goes for the ordering cases: an extended write racing an in-flight command, and a clear racing a drop.

// File: rtl/hcmd_pkg.sv
package hcmd_pkg;
  localparam int CODE_W  = 4;
  localparam int NUM_OPS = 11;

  typedef enum logic [CODE_W-1:0] {
    OP_LINK_RATE  = 4'd0,
    OP_CH_OPEN    = 4'd1,
    OP_CH_CLOSE   = 4'd2,
    OP_IPCH_OPEN  = 4'd3,
    OP_IPCH_CLOSE = 4'd4,
    OP_TX_READY   = 4'd5,
    OP_FLOW_READY = 4'd6,
    OP_ADD_BUF    = 4'd7,
    OP_INDIRECT   = 4'd8,
    OP_RX_CONGEST = 4'd9,
    OP_BRM_SEND   = 4'd10
  } op_e;

  // A code is defined when it falls inside the command table.
  function automatic logic code_known(input logic [CODE_W-1:0] c);
    return int'(c) < NUM_OPS;
  endfunction

  // Commands that consume the extended register as operand.
  function automatic logic takes_operand(input logic [CODE_W-1:0] c, input logic ipoa);
    case (c)
      OP_INDIRECT, OP_ADD_BUF: return 1'b1;
      OP_TX_READY:             return ipoa;
      default:                 return 1'b0;
    endcase
  endfunction

  // Commands whose completion overwrites the command register with an indication.
  function automatic logic returns_ind(input logic [CODE_W-1:0] c);
    case (c)
      OP_CH_OPEN, OP_CH_CLOSE, OP_IPCH_OPEN, OP_IPCH_CLOSE,
      OP_TX_READY, OP_ADD_BUF: return 1'b1;
      default:                 return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/hcmd_decode.sv
module hcmd_decode
  import hcmd_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              ipoa,
  output logic              known,
  output logic              use_ext,
  output logic              give_ind
);
  always_comb begin
    known    = code_known(code);
    use_ext  = known && takes_operand(code, ipoa);
    give_ind = known && returns_ind(code);
  end
endmodule

// File: rtl/hcmd_ctrl.sv
module hcmd_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_wr,
  input  logic code_ok,
  input  logic exe_done,
  input  logic err_clr,
  output logic busy,
  output logic exe_start,
  output logic drop_err,
  output logic accept_evt,
  output logic bad_evt,
  output logic drop_evt,
  output logic finish_evt
);
  always_comb begin
    accept_evt = cmd_wr && !busy && code_ok;
    bad_evt    = cmd_wr && !busy && !code_ok;
    drop_evt   = cmd_wr && busy;
    finish_evt = busy && exe_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      exe_start <= 1'b0;
      drop_err  <= 1'b0;
    end else begin
      exe_start <= accept_evt;
      if (accept_evt)      busy <= 1'b1;
      else if (finish_evt) busy <= 1'b0;
      if (drop_evt)        drop_err <= 1'b1;
      else if (err_clr)    drop_err <= 1'b0;
    end
  end
endmodule

// File: rtl/hcmd_regfile.sv
module hcmd_regfile
  import hcmd_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int STAT_W   = 8,
  parameter int STAT_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              accept_evt,
  input  logic              bad_evt,
  input  logic              finish_evt,
  input  logic              use_ext,
  input  logic              give_ind,
  input  logic [STAT_W-1:0] exe_status,
  input  logic [DATA_W-1:0] exe_rdata,
  input  logic              exe_rdata_vld,
  output logic [DATA_W-1:0] cmd_body,
  output logic [DATA_W-1:0] ext_q,
  output logic [DATA_W-1:0] arg_q,
  output logic [CODE_W-1:0] kind_q
);
  localparam int BUSY_BIT = DATA_W - 1;
  localparam int IND_BIT  = DATA_W - 2;
  localparam int BAD_BIT  = DATA_W - 3;

  logic ind_q;

  function automatic logic [DATA_W-1:0] body_word(input logic [DATA_W-1:0] w);
    logic [DATA_W-1:0] r;
    r = w;
    r[BUSY_BIT] = 1'b0;
    r[IND_BIT]  = 1'b0;
    r[BAD_BIT]  = 1'b0;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] ind_word(input logic [CODE_W-1:0] c,
                                                 input logic [STAT_W-1:0] s);
    logic [DATA_W-1:0] r;
    r = '0;
    r[IND_BIT] = 1'b1;
    r[STAT_LSB +: STAT_W] = s;
    r[CODE_W-1:0] = c;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] bad_word(input logic [CODE_W-1:0] c);
    logic [DATA_W-1:0] r;
    r = '0;
    r[BAD_BIT] = 1'b1;
    r[CODE_W-1:0] = c;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_body <= '0;
      arg_q    <= '0;
      kind_q   <= '0;
      ind_q    <= 1'b0;
    end else if (accept_evt) begin
      cmd_body <= body_word(wdata);
      arg_q    <= use_ext ? ext_q : '0;
      kind_q   <= wdata[CODE_W-1:0];
      ind_q    <= give_ind;
    end else if (bad_evt) begin
      cmd_body <= bad_word(wdata[CODE_W-1:0]);
    end else if (finish_evt && ind_q) begin
      cmd_body <= ind_word(kind_q, exe_status);
    end
  end

  // Result write-back takes priority over a host write in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ext_q <= '0;
    else if (finish_evt && exe_rdata_vld) ext_q <= exe_rdata;
    else if (ext_wr)                     ext_q <= wdata;
  end
endmodule

// File: rtl/hcmd_port.sv
module hcmd_port
  import hcmd_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int STAT_W   = 8,
  parameter int STAT_LSB = 16,
  parameter int IPOA_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_wr_en,
  input  logic              hst_wr_sel,
  input  logic [DATA_W-1:0] hst_wr_data,
  input  logic              hst_err_clr,
  output logic [DATA_W-1:0] rd_cmd,
  output logic [DATA_W-1:0] rd_ext,
  output logic              drop_err,
  output logic              exe_start,
  output logic [CODE_W-1:0] exe_kind,
  output logic [DATA_W-1:0] exe_arg,
  input  logic              exe_done,
  input  logic [STAT_W-1:0] exe_status,
  input  logic [DATA_W-1:0] exe_rdata,
  input  logic              exe_rdata_vld
);
  localparam int BUSY_BIT = DATA_W - 1;

  logic cmd_wr, ext_wr;
  logic known, use_ext, give_ind;
  logic busy;
  logic accept_evt, bad_evt, drop_evt, finish_evt;
  logic [DATA_W-1:0] cmd_body;

  assign cmd_wr = hst_wr_en && !hst_wr_sel;
  assign ext_wr = hst_wr_en && hst_wr_sel;

  hcmd_decode u_dec (
    .code     (hst_wr_data[CODE_W-1:0]),
    .ipoa     (hst_wr_data[IPOA_BIT]),
    .known    (known),
    .use_ext  (use_ext),
    .give_ind (give_ind)
  );

  hcmd_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (cmd_wr),
    .code_ok    (known),
    .exe_done   (exe_done),
    .err_clr    (hst_err_clr),
    .busy       (busy),
    .exe_start  (exe_start),
    .drop_err   (drop_err),
    .accept_evt (accept_evt),
    .bad_evt    (bad_evt),
    .drop_evt   (drop_evt),
    .finish_evt (finish_evt)
  );

  hcmd_regfile #(
    .DATA_W   (DATA_W),
    .STAT_W   (STAT_W),
    .STAT_LSB (STAT_LSB)
  ) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .ext_wr        (ext_wr),
    .wdata         (hst_wr_data),
    .accept_evt    (accept_evt),
    .bad_evt       (bad_evt),
    .finish_evt    (finish_evt),
    .use_ext       (use_ext),
    .give_ind      (give_ind),
    .exe_status    (exe_status),
    .exe_rdata     (exe_rdata),
    .exe_rdata_vld (exe_rdata_vld),
    .cmd_body      (cmd_body),
    .ext_q         (rd_ext),
    .arg_q         (exe_arg),
    .kind_q        (exe_kind)
  );

  always_comb begin
    rd_cmd = cmd_body;
    rd_cmd[BUSY_BIT] = busy;
  end
endmodule

// File: rtl/hcmd_port_chk.sv
module hcmd_port_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hst_wr_en,
  input logic              hst_wr_sel,
  input logic              busy,
  input logic              exe_start,
  input logic              exe_done,
  input logic [DATA_W-1:0] exe_arg,
  input logic              drop_err,
  input logic              accept_evt,
  input logic              bad_evt,
  input logic              drop_evt
);
  // R2
  accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> (exe_start && busy));

  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exe_start |=> !exe_start);

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !exe_done) |=> busy);

  // R3
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && exe_done) |=> !busy);

  // R4
  ext_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_wr_en && hst_wr_sel && !busy) |=> (!busy && !exe_start));

  // R5
  arg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(exe_arg));

  // R9
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> (drop_err && !exe_start));

  // R10
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_evt |=> (!busy && !exe_start));
endmodule

bind hcmd_port hcmd_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hst_wr_en  (hst_wr_en),
  .hst_wr_sel (hst_wr_sel),
  .busy       (busy),
  .exe_start  (exe_start),
  .exe_done   (exe_done),
  .exe_arg    (exe_arg),
  .drop_err   (drop_err),
  .accept_evt (accept_evt),
  .bad_evt    (bad_evt),
  .drop_evt   (drop_evt)
);

// File: tb/hcmd_port_tb_top.sv
`timescale 1ns/1ps
module hcmd_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_wr_en = 1'b0;
  logic        hst_wr_sel = 1'b0;
  logic [31:0] hst_wr_data = '0;
  logic        hst_err_clr = 1'b0;
  logic [31:0] rd_cmd, rd_ext, exe_arg;
  logic        drop_err, exe_start;
  logic [3:0]  exe_kind;
  logic        exe_done = 1'b0;
  logic [7:0]  exe_status = '0;
  logic [31:0] exe_rdata = '0;
  logic        exe_rdata_vld = 1'b0;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  hcmd_port dut_i (
    .clk(clk), .rst_n(rst_n), .hst_wr_en(hst_wr_en), .hst_wr_sel(hst_wr_sel),
    .hst_wr_data(hst_wr_data), .hst_err_clr(hst_err_clr), .rd_cmd(rd_cmd),
    .rd_ext(rd_ext), .drop_err(drop_err), .exe_start(exe_start),
    .exe_kind(exe_kind), .exe_arg(exe_arg), .exe_done(exe_done),
    .exe_status(exe_status), .exe_rdata(exe_rdata), .exe_rdata_vld(exe_rdata_vld)
  );

  typedef struct packed {
    logic [3:0]  code;
    logic        ipoa;
    logic [31:0] ext;
    logic [7:0]  stat;
    logic        rvld;
    logic [31:0] rdata;
    logic [2:0]  dly;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{4'd1,  1'b0, 32'h1111_2222, 8'h01, 1'b0, 32'h0,         3'd0},
    '{4'd5,  1'b1, 32'hCAFE_0005, 8'h05, 1'b0, 32'h0,         3'd2},
    '{4'd5,  1'b0, 32'hDEAD_0055, 8'h06, 1'b0, 32'h0,         3'd1},
    '{4'd7,  1'b0, 32'h0000_0040, 8'h07, 1'b1, 32'h0000_0041, 3'd3},
    '{4'd8,  1'b0, 32'h8000_0100, 8'h00, 1'b1, 32'h1234_5678, 3'd4},
    '{4'd0,  1'b0, 32'h0000_0009, 8'h33, 1'b0, 32'h0,         3'd0},
    '{4'd10, 1'b1, 32'h0BAD_F00D, 8'h44, 1'b0, 32'h0,         3'd1},
    '{4'd2,  1'b0, 32'h2222_0000, 8'hFF, 1'b0, 32'h0,         3'd5},
    '{4'd3,  1'b1, 32'h3333_0000, 8'h80, 1'b0, 32'h0,         3'd0},
    '{4'd4,  1'b0, 32'h4444_0000, 8'h7E, 1'b1, 32'hAAAA_5555, 3'd2},
    '{4'd6,  1'b0, 32'h6666_0000, 8'h12, 1'b0, 32'h0,         3'd1},
    '{4'd9,  1'b0, 32'h9999_0000, 8'h99, 1'b1, 32'h0000_9999, 3'd0}
  };

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    hst_wr_en = 1'b1; hst_wr_sel = sel; hst_wr_data = d;
    @(negedge clk);
    hst_wr_en = 1'b0; hst_wr_sel = 1'b0; hst_wr_data = '0;
  endtask

  task automatic finish_exec(input logic [7:0] s, input logic v, input logic [31:0] d);
    @(negedge clk);
    exe_done = 1'b1; exe_status = s; exe_rdata_vld = v; exe_rdata = d;
    @(negedge clk);
    exe_done = 1'b0; exe_status = '0; exe_rdata_vld = 1'b0; exe_rdata = '0;
  endtask

  function automatic logic [31:0] cmd_word(input logic [3:0] c, input logic ipoa);
    return {8'h00, 8'h5A, 8'h00, 3'b000, ipoa, c};
  endfunction

  function automatic logic bench_uses_ext(input logic [3:0] c, input logic ipoa);
    return (c == 4'd8) || (c == 4'd7) || (c == 4'd5 && ipoa);
  endfunction

  function automatic logic bench_gives_ind(input logic [3:0] c);
    return (c >= 4'd1 && c <= 4'd5) || (c == 4'd7);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] w, exp_cmd, exp_arg, exp_ext;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rd_cmd == 32'h0, "R1 rd_cmd", rd_cmd, 32'h0);
    check(rd_ext == 32'h0, "R1 rd_ext", rd_ext, 32'h0);
    check({exe_start, drop_err} == 2'b00, "R1 start/err", {30'h0, exe_start, drop_err}, 32'h0);
    check(exe_arg == 32'h0, "R1 exe_arg", exe_arg, 32'h0);

    // R4 extended write alone
    host_write(1'b1, 32'h5555_AAAA);
    check(rd_ext == 32'h5555_AAAA, "R4 ext stored", rd_ext, 32'h5555_AAAA);
    check(!rd_cmd[31] && !exe_start, "R4 no start", rd_cmd, 32'h0);

    // Vector table walk: R2 R3 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      w = cmd_word(VEC[i].code, VEC[i].ipoa);
      host_write(1'b1, VEC[i].ext);
      host_write(1'b0, w);
      check(rd_cmd[31] && exe_start, "R2 busy+start", rd_cmd, {1'b1, w[30:0]});
      check(exe_kind == VEC[i].code, "R2 exe_kind", {28'h0, exe_kind}, {28'h0, VEC[i].code});
      exp_arg = bench_uses_ext(VEC[i].code, VEC[i].ipoa) ? VEC[i].ext : 32'h0;
      check(exe_arg == exp_arg, "R5 exe_arg", exe_arg, exp_arg);
      for (int d = 0; d < int'(VEC[i].dly); d++) begin
        @(negedge clk);
        check(rd_cmd[31] && !exe_start, "R3 busy held", rd_cmd, {1'b1, w[30:0]});
      end
      finish_exec(VEC[i].stat, VEC[i].rvld, VEC[i].rdata);
      if (bench_gives_ind(VEC[i].code))
        exp_cmd = {1'b0, 1'b1, 6'b0, VEC[i].stat, 12'h000, VEC[i].code};
      else
        exp_cmd = {3'b000, w[28:0]};
      check(rd_cmd == exp_cmd, bench_gives_ind(VEC[i].code) ? "R6 indication" : "R7 word kept",
            rd_cmd, exp_cmd);
      check(!rd_cmd[31], "R3 busy released", rd_cmd, exp_cmd);
      exp_ext = VEC[i].rvld ? VEC[i].rdata : VEC[i].ext;
      check(rd_ext == exp_ext, "R8 ext after done", rd_ext, exp_ext);
    end

    // R5 R9: operand frozen and command dropped while busy
    host_write(1'b1, 32'hA0A0_0001);
    w = cmd_word(4'd8, 1'b0);
    host_write(1'b0, w);
    host_write(1'b1, 32'hB0B0_0002);
    check(exe_arg == 32'hA0A0_0001, "R5 arg frozen", exe_arg, 32'hA0A0_0001);
    check(rd_ext == 32'hB0B0_0002, "R4 ext updated while busy", rd_ext, 32'hB0B0_0002);
    host_write(1'b0, cmd_word(4'd1, 1'b0));
    check(rd_cmd == {1'b1, w[30:0]}, "R9 cmd unchanged", rd_cmd, {1'b1, w[30:0]});
    check(!exe_start && drop_err, "R9 dropped", {30'h0, exe_start, drop_err}, 32'h1);
    @(negedge clk);
    check(!exe_start && drop_err, "R9 no late start", {30'h0, exe_start, drop_err}, 32'h1);
    check(exe_kind == 4'd8, "R9 kind kept", {28'h0, exe_kind}, 32'h8);
    finish_exec(8'h00, 1'b0, 32'h0);
    check(rd_cmd == {3'b000, w[28:0]}, "R7 after drop", rd_cmd, {3'b000, w[28:0]});
    check(rd_ext == 32'hB0B0_0002, "R8 no result", rd_ext, 32'hB0B0_0002);

    // R11 clear, then clear racing a drop
    @(negedge clk); hst_err_clr = 1'b1;
    @(negedge clk); hst_err_clr = 1'b0;
    check(!drop_err, "R11 cleared", {31'h0, drop_err}, 32'h0);
    host_write(1'b0, cmd_word(4'd6, 1'b0));
    @(negedge clk);
    hst_wr_en = 1'b1; hst_wr_sel = 1'b0; hst_wr_data = cmd_word(4'd2, 1'b0); hst_err_clr = 1'b1;
    @(negedge clk);
    hst_wr_en = 1'b0; hst_wr_data = '0; hst_err_clr = 1'b0;
    check(drop_err, "R11 set wins", {31'h0, drop_err}, 32'h1);
    finish_exec(8'h00, 1'b0, 32'h0);

    // R10 undefined codes
    for (int c = 11; c < 16; c++) begin
      host_write(1'b0, cmd_word(4'(c), 1'b0));
      exp_cmd = 32'h2000_0000 | 32'(c);
      check(rd_cmd == exp_cmd, "R10 bad indication", rd_cmd, exp_cmd);
      check(!exe_start, "R10 no start", {31'h0, exe_start}, 32'h0);
      @(negedge clk);
      check(!exe_start && !rd_cmd[31], "R10 stays idle", rd_cmd, exp_cmd);
    end

    // R3 done while idle changes nothing
    finish_exec(8'hEE, 1'b1, 32'hFFFF_FFFF);
    check(rd_cmd == 32'h2000_000F, "R3 idle done ignored", rd_cmd, 32'h2000_000F);
    check(rd_ext == 32'hB0B0_0002, "R8 idle done no result", rd_ext, 32'hB0B0_0002);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule